// File: doc/BRIEF.md
# Packed Dual-Channel Tone Correlator

This block is the correlation cell for a single calibration tone. Eight channels of 2-bit sample data share one complex phasor, given as 6-bit real and imaginary parts. The cell correlates each channel against that phasor and keeps a running real and imaginary sum for every channel. There is one unsigned multiplier in the cell. Each sample period is split into four clock slots, and each slot serves one pair of channels.

In a slot, the two samples of the pair go into one operand: the lower-numbered channel in the top two bits and the other channel in the bottom two bits. The two phasor parts go into the other operand, spaced apart. With these placements the four cross products fall into disjoint 8-bit fields of the result, so they can be read out directly.

The samples and phasor are offset-binary values. Bias removal is done later by software. A dump pulse copies all sixteen sums to the outputs and starts a new integration period.

Top module: `tone_corr_cell`

## Requirements
- R1: The operands are packed as follows. Sample operand: channel 2k in bits 17:16, channel 2k+1 in bits 1:0. Phasor operand: real part in bits 13:8, imaginary part in bits 5:0. Per slot, the real sum of channel 2k gains (its sample × real part), its imaginary sum gains (sample × imaginary part), and channel 2k+1 gains the same two products from its own sample.
- R2: All arithmetic is unsigned. A sample of 3 against a phasor part of 63 adds exactly 189, and no product bit above bit 31 is ever set.
- R3: When the validity flag latched with a sample is low, that sample period adds nothing to any sum.
- R4: A strobe cycle latches the samples, phasor and validity. It is followed by four slots processed in order, k = 0,1,2,3, serving channels 2k and 2k+1. Slot 0 is the cycle after the strobe. Slot 3 falls on the next strobe cycle when strobes come every fourth cycle.
- R5: When dump is high in a cycle, each output takes the sum held before that cycle. The contribution of that cycle starts the new period, so no sample is lost.
- R6: While reset is low, all sums and outputs are zero and no slot is active.
- R7: Outputs change only on a dump cycle.
- R8: Changes on the sample, phasor or validity inputs in non-strobe cycles have no effect on the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four cycles per sample period |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, latches the inputs below |
| smp_in | input | 16 | Channel i sample in bits 2i+1:2i |
| smp_vld | input | 1 | Validity of the strobed samples |
| ph_re | input | 6 | Phasor real part, unsigned |
| ph_im | input | 6 | Phasor imaginary part, unsigned |
| dump | input | 1 | Ends an integration period |
| re_out | output | 256 | Channel i real sum in bits 32i+31:32i |
| im_out | output | 256 | Channel i imaginary sum in bits 32i+31:32i |

## Verification
The hardest case to reach is a dump pulse that lands inside the four-slot window. Some channel pairs must then be credited to the old period and the rest to the new one. Two conditions can hide a fault: a dump that drops the current contribution, and a dump that counts it twice. The stimulus places dump pulses at random cycle offsets relative to the strobe, so every slot position is hit. The non-strobe inputs are also filled with random values, so that any leakage from them into the sums shows up at the next dump.

// File: rtl/tone_corr_cell.sv
module tone_corr_cell #(
  parameter int NCH = 8,
  parameter int SW  = 2,
  parameter int PW  = 6,
  parameter int AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic              smp_vld,
  input  logic [PW-1:0]     ph_re,
  input  logic [PW-1:0]     ph_im,
  input  logic              dump,
  output logic [NCH*AW-1:0] re_out,
  output logic [NCH*AW-1:0] im_out
);
  localparam int NPAIR = NCH / 2;
  localparam int KW    = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int FW    = SW + PW;
  localparam int OAW   = 2*FW + SW;
  localparam int OBW   = FW + PW;
  localparam int MW    = (OAW > OBW) ? OAW : OBW;
  localparam int PRW   = 2*MW;

  logic [NCH*SW-1:0] smp_l;
  logic [PW-1:0]     re_l, im_l;
  logic              vld_l, busy;
  logic [KW-1:0]     k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_l <= '0; re_l <= '0; im_l <= '0; vld_l <= 1'b0;
      busy  <= 1'b0; k <= '0;
    end else if (smp_stb) begin
      smp_l <= smp_in; re_l <= ph_re; im_l <= ph_im; vld_l <= smp_vld;
      busy  <= 1'b1; k <= '0;
    end else if (busy) begin
      k <= k + 1'b1;
      if (k == KW'(NPAIR-1)) busy <= 1'b0;
    end
  end

  logic [SW-1:0]  sa, sb;
  logic [MW-1:0]  op_a, op_b;
  logic [PRW-1:0] prod;
  logic [FW-1:0]  p_ac, p_ad, p_bc, p_bd;

  assign sa   = smp_l[(2*k)*SW +: SW];
  assign sb   = smp_l[(2*k+1)*SW +: SW];
  assign op_a = MW'({sa, {(2*FW-SW){1'b0}}, sb});
  assign op_b = MW'({re_l, {(FW-PW){1'b0}}, im_l});
  assign prod = {{MW{1'b0}}, op_a} * {{MW{1'b0}}, op_b};
  assign p_ac = prod[3*FW +: FW];
  assign p_ad = prod[2*FW +: FW];
  assign p_bc = prod[FW +: FW];
  assign p_bd = prod[0 +: FW];

  logic [NCH*AW-1:0] acc_re, acc_im;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          hit;
    logic [FW-1:0] inc_re, inc_im;
    assign hit    = busy && vld_l && (k == KW'(ch/2));
    if (ch % 2 == 0) begin : g_hi
      assign inc_re = hit ? p_ac : '0;
      assign inc_im = hit ? p_ad : '0;
    end else begin : g_lo
      assign inc_re = hit ? p_bc : '0;
      assign inc_im = hit ? p_bd : '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_re[ch*AW +: AW] <= '0;
        acc_im[ch*AW +: AW] <= '0;
        re_out[ch*AW +: AW] <= '0;
        im_out[ch*AW +: AW] <= '0;
      end else if (dump) begin
        re_out[ch*AW +: AW] <= acc_re[ch*AW +: AW];
        im_out[ch*AW +: AW] <= acc_im[ch*AW +: AW];
        acc_re[ch*AW +: AW] <= AW'(inc_re);
        acc_im[ch*AW +: AW] <= AW'(inc_im);
      end else begin
        acc_re[ch*AW +: AW] <= acc_re[ch*AW +: AW] + AW'(inc_re);
        acc_im[ch*AW +: AW] <= acc_im[ch*AW +: AW] + AW'(inc_im);
      end
    end
  end
endmodule

// File: rtl/tone_corr_cell_chk.sv
module tone_corr_cell_chk #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int KW  = 2,
  parameter int PRW = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic              dump,
  input logic              busy,
  input logic              vld_l,
  input logic [KW-1:0]     k,
  input logic [PRW-1:0]    prod,
  input logic [NCH*AW-1:0] acc_re,
  input logic [NCH*AW-1:0] acc_im,
  input logic [NCH*AW-1:0] re_out,
  input logic [NCH*AW-1:0] im_out
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> ($stable(re_out) && $stable(im_out))); // R7
  AST_DUMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (re_out == $past(acc_re) && im_out == $past(acc_im))); // R5
  AST_VLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_l && !dump && !smp_stb) |=> ($stable(acc_re) && $stable(acc_im))); // R3
  AST_SLOT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !smp_stb && k != KW'(2**KW-1)) |=> (busy && k == KW'($past(k) + 1'b1))); // R4
  AST_NO_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (prod[PRW-1:32] == '0)); // R2
  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!busy && re_out == '0 && im_out == '0)); // R6
endmodule

bind tone_corr_cell tone_corr_cell_chk #(
  .NCH(NCH), .AW(AW), .KW(KW), .PRW(PRW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .dump(dump),
  .busy(busy), .vld_l(vld_l), .k(k), .prod(prod),
  .acc_re(acc_re), .acc_im(acc_im), .re_out(re_out), .im_out(im_out)
);

// File: tb/tone_corr_cell_bench.sv
module tone_corr_cell_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_stb = 1'b0;
  logic [15:0]  smp_in = '0;
  logic         smp_vld = 1'b0;
  logic [5:0]   ph_re = '0, ph_im = '0;
  logic         dump = 1'b0;
  logic [255:0] re_out, im_out;

  int checks = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  tone_corr_cell u_tone_corr_cell (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .smp_vld(smp_vld), .ph_re(ph_re), .ph_im(ph_im), .dump(dump),
    .re_out(re_out), .im_out(im_out)
  );

  always #2 clk = ~clk;

  int unsigned m_re[8], m_im[8], ls[8];
  int unsigned lc, ld, mk;
  bit lv, mbusy;

  function automatic int unsigned f_gain(int unsigned s, int unsigned p);
    return s * p;
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp, int ch);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, ch, act, exp);
    end
  endtask

  task automatic cyc1(string tag, bit dmp, bit vld, logic [15:0] s,
                      logic [5:0] c, logic [5:0] d, bit scramble);
    bit stb;
    int unsigned e_re[8], e_im[8];
    @(negedge clk);
    stb = (cyc % 4 == 0);
    smp_stb = stb; dump = dmp;
    if (stb) begin
      smp_in = s; smp_vld = vld; ph_re = c; ph_im = d;
    end else if (scramble) begin
      smp_in = 16'($urandom()); smp_vld = 1'($urandom());
      ph_re = 6'($urandom()); ph_im = 6'($urandom());
    end
    @(posedge clk);
    for (int ch = 0; ch < 8; ch++) begin
      int unsigned ir, ii;
      ir = 0; ii = 0;
      if (mbusy && lv && mk == ch/2) begin
        ir = f_gain(ls[ch], lc); ii = f_gain(ls[ch], ld);
      end
      if (dmp) begin
        e_re[ch] = m_re[ch]; e_im[ch] = m_im[ch];
        m_re[ch] = ir; m_im[ch] = ii;
      end else begin
        m_re[ch] += ir; m_im[ch] += ii;
      end
    end
    if (stb) begin
      for (int ch = 0; ch < 8; ch++) ls[ch] = s[2*ch +: 2];
      lc = c; ld = d; lv = vld; mk = 0; mbusy = 1'b1;
    end else if (mbusy) begin
      if (mk == 3) mbusy = 1'b0; else mk++;
    end
    cyc++;
    #1;
    if (dmp)
      for (int ch = 0; ch < 8; ch++) begin
        chk({tag, " re"}, re_out[32*ch +: 32], e_re[ch], ch);
        chk({tag, " im"}, im_out[32*ch +: 32], e_im[ch], ch);
      end
  endtask

  task automatic flush(string tag);
    for (int i = 0; i < 8; i++) cyc1(tag, 1'b0, 1'b0, '0, '0, '0, 1'b0);
    while (cyc % 4 != 0) cyc1(tag, 1'b0, 1'b0, '0, '0, '0, 1'b0);
    cyc1(tag, 1'b1, 1'b0, '0, '0, '0, 1'b0);
  endtask

  initial begin
    for (int ch = 0; ch < 8; ch++) begin m_re[ch] = 0; m_im[ch] = 0; ls[ch] = 0; end
    lc = 0; ld = 0; lv = 0; mk = 0; mbusy = 0;
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(posedge clk);
    #1;
    for (int ch = 0; ch < 8; ch++) begin
      chk("R6 reset re", re_out[32*ch +: 32], 0, ch);
      chk("R6 reset im", im_out[32*ch +: 32], 0, ch);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: full-scale samples against full-scale phasor, 189 per sample
    for (int i = 0; i < 20; i++) cyc1("R2 fullscale", 1'b0, 1'b1, 16'hFFFF, 6'd63, 6'd63, 1'b0);
    flush("R2 fullscale");
    // R1 R4: distinct channel values expose pair and field mapping
    for (int i = 0; i < 16; i++) cyc1("R1 R4 mapping", 1'b0, 1'b1, 16'b00_01_10_11_11_10_01_00, 6'd1, 6'd40, 1'b0);
    flush("R1 R4 mapping");
    // R3: invalid samples with scrambled inputs leave sums at zero
    for (int i = 0; i < 24; i++) cyc1("R3 invalid", 1'b0, 1'b0, 16'hFFFF, 6'd63, 6'd63, 1'b1);
    flush("R3 invalid");
    // R5: dump at each slot offset inside the window
    for (int off = 0; off < 4; off++) begin
      for (int i = 0; i < 12 + off; i++) cyc1("R5 dump slot", 1'b0, 1'b1, 16'hA5C3, 6'd17, 6'd50, 1'b0);
      cyc1("R5 dump slot", 1'b1, 1'b1, 16'hA5C3, 6'd17, 6'd50, 1'b0);
      cyc1("R5 dump slot", 1'b0, 1'b1, 16'hA5C3, 6'd17, 6'd50, 1'b0);
      flush("R5 dump slot");
    end
    // R8 R7: random stimulus, scrambled off-strobe inputs, random dumps
    for (int i = 0; i < 3000; i++)
      cyc1("R8 R7 random", ($urandom() % 37) == 0, ($urandom() % 4) != 0,
           16'($urandom()), 6'($urandom()), 6'($urandom()), 1'b1);
    flush("R8 random");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule